// File: doc/BRIEF.md
# Socket Activity Indicator Pulse Stretcher

This block drives a single active-high indicator output that lights while a card socket is being used. It watches bus strobes from the card: the ready/interrupt line of a 16-bit card, or the frame, initiator-ready and request strobes of a 32-bit card-bus card. A card-type input selects which of the two sets of strobes counts. Each qualifying event lights the output for a fixed window of `PULSE_CYCLES` clock cycles. The window is meant to be 64 ms. A new event during the window starts the window again, so regular traffic keeps the output lit without a gap.

Events count only while a card is present, powered and out of reset. The output is forced dark at once whenever the bus clock may be stopped or the device leaves full power. This covers suspend, a pending clock-stop request, and the D1 and D2 power states. In these cases the counter is cleared, so the indicator can never freeze in the lit state. When the condition ends, the output stays dark until a new event arrives.

Top module: `sock_led_stretch`

## Requirements
- R1: While `rst_n` is low, and after reset until the first qualifying event, `led` is low.
- R2: One qualifying card-bus event that is sampled at a rising edge drives `led` high from that edge for exactly `PULSE_CYCLES` cycles. After that `led` returns low.
- R3: A qualifying event while `led` is high restarts the window. `led` then stays high without a gap until `PULSE_CYCLES` cycles after the last event.
- R4: With `card_is_bus` = 1, a low level on any one of `cb_frame_n`, `cb_irdy_n` or `cb_req_n` is a qualifying event.
- R5: With `card_is_bus` = 0, a low level on `rdy_irq_n` is a qualifying event. It passes through a two-stage synchronizer, so `led` rises at the third rising edge after the line goes low.
- R6: The strobes of the card type that is not selected have no effect on `led`.
- R7: When `card_present` is low, `card_powered` is low or `card_in_reset` is high, no event is recognized. `led` is low in the same cycle, and a pulse that was running does not resume when the card becomes usable again.
- R8: While `suspend` or `clk_stop_req` is high, `led` is low in the same cycle and events are ignored. After the condition clears, `led` stays low until a new event arrives.
- R9: `pwr_state` values 1 (D1) and 2 (D2) cut the output off in the same way as R8. Values 0 (D0) and 3 (D3) do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| card_present | input | 1 | A card is inserted |
| card_powered | input | 1 | Socket power is applied |
| card_in_reset | input | 1 | The card is held in reset |
| card_is_bus | input | 1 | 1: 32-bit card-bus card, 0: 16-bit card |
| rdy_irq_n | input | 1 | 16-bit ready/interrupt line, asynchronous, active low |
| cb_frame_n | input | 1 | Card-bus frame strobe, active low |
| cb_irdy_n | input | 1 | Card-bus initiator-ready strobe, active low |
| cb_req_n | input | 1 | Card-bus request strobe, active low |
| suspend | input | 1 | Suspend request, forces the output off |
| clk_stop_req | input | 1 | Clock-run stop pending, forces the output off |
| pwr_state | input | 2 | Device power state, 0 to 3 for D0 to D3 |
| led | output | 1 | Activity indicator, active high |

## Verification
The bench measures the exact length of the lit window and checks its end. A counter that is off by one lights the output for one cycle too many or too few. A counter that ignores restarts goes dark in the middle of continuous traffic. The bench also checks the three-edge delay on the 16-bit path. A design that skips the synchronizer, or adds a stage to it, shifts the rising edge. The cut-off tests turn suspend, clock-stop, D1/D2 and card removal on in the middle of a pulse, and then turn them off again. A design that only masks the output, and does not clear the counter, lights up again with a stale pulse. The bench also drives strobes of the card type that is not selected. A design that selects the wrong source lights the output from traffic it should ignore.

// File: rtl/sock_led_pkg.sv
package sock_led_pkg;

  // Device power states; only the intermediate two cut the indicator off.
  typedef enum logic [1:0] {
    PWR_D0 = 2'd0,
    PWR_D1 = 2'd1,
    PWR_D2 = 2'd2,
    PWR_D3 = 2'd3
  } pwr_state_e;

  // Source selection for activity qualification.
  typedef enum logic {
    CARD_16BIT = 1'b0,
    CARD_BUS   = 1'b1
  } card_kind_e;

endpackage

// File: rtl/sock_led_sync.sv
module sock_led_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE_LV}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sock_led_qual.sv
module sock_led_qual
  import sock_led_pkg::*;
(
  input  logic       card_present,
  input  logic       card_powered,
  input  logic       card_in_reset,
  input  logic       card_is_bus,
  input  logic       rdy_sync_n,
  input  logic       cb_frame_n,
  input  logic       cb_irdy_n,
  input  logic       cb_req_n,
  input  logic       suspend,
  input  logic       clk_stop_req,
  input  logic [1:0] pwr_state,
  output logic       act_ev,
  output logic       hold
);

  pwr_state_e pwr;
  card_kind_e kind;
  logic       cut_off;
  logic       card_ok;
  logic       src_act;

  always_comb begin
    pwr     = pwr_state_e'(pwr_state);
    kind    = card_kind_e'(card_is_bus);
    cut_off = suspend | clk_stop_req | (pwr == PWR_D1) | (pwr == PWR_D2);
    card_ok = card_present & card_powered & ~card_in_reset;

    unique case (kind)
      CARD_BUS:   src_act = ~cb_frame_n | ~cb_irdy_n | ~cb_req_n;
      CARD_16BIT: src_act = ~rdy_sync_n;
      default:    src_act = 1'b0;
    endcase

    hold   = cut_off | ~card_ok;
    act_ev = src_act & ~hold;
  end

endmodule

// File: rtl/sock_led_timer.sv
module sock_led_timer #(
  parameter int unsigned PULSE_CYCLES = 10,
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_ev,
  input  logic          hold,
  output logic          run,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign run = (cnt_q != '0);
  assign cnt = cnt_q;

  always_comb begin
    cnt_en = hold | act_ev | run;
    cnt_d  = cnt_q;
    if (hold) begin
      cnt_d = '0;
    end else if (act_ev) begin
      cnt_d = LOAD_VAL;
    end else if (run) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sock_led_stretch.sv
module sock_led_stretch #(
  parameter int unsigned PULSE_CYCLES = 6400000,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       card_present,
  input  logic       card_powered,
  input  logic       card_in_reset,
  input  logic       card_is_bus,
  input  logic       rdy_irq_n,
  input  logic       cb_frame_n,
  input  logic       cb_irdy_n,
  input  logic       cb_req_n,
  input  logic       suspend,
  input  logic       clk_stop_req,
  input  logic [1:0] pwr_state,
  output logic       led
);

  logic          rdy_sync_n;
  logic          act_ev;
  logic          hold;
  logic          run;
  logic [CW-1:0] cnt_q;

  sock_led_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE_LV(1'b1)
  ) i_rdy_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(rdy_irq_n),
    .d_sync (rdy_sync_n)
  );

  sock_led_qual i_qual (
    .card_present (card_present),
    .card_powered (card_powered),
    .card_in_reset(card_in_reset),
    .card_is_bus  (card_is_bus),
    .rdy_sync_n   (rdy_sync_n),
    .cb_frame_n   (cb_frame_n),
    .cb_irdy_n    (cb_irdy_n),
    .cb_req_n     (cb_req_n),
    .suspend      (suspend),
    .clk_stop_req (clk_stop_req),
    .pwr_state    (pwr_state),
    .act_ev       (act_ev),
    .hold         (hold)
  );

  sock_led_timer #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .act_ev(act_ev),
    .hold  (hold),
    .run   (run),
    .cnt   (cnt_q)
  );

  // Gate with hold so a cut-off darkens the output within the same cycle.
  assign led = run & ~hold;

endmodule

// File: rtl/sock_led_chk.sv
module sock_led_chk #(
  parameter int unsigned PULSE_CYCLES = 10,
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          card_present,
  input logic          card_powered,
  input logic          card_in_reset,
  input logic          suspend,
  input logic          clk_stop_req,
  input logic [1:0]    pwr_state,
  input logic          act_ev,
  input logic [CW-1:0] cnt_q,
  input logic          led
);

  logic low_pwr;
  logic card_bad;
  assign low_pwr  = (pwr_state == 2'd1) || (pwr_state == 2'd2);
  assign card_bad = !card_present || !card_powered || card_in_reset;

  assert_reset_dark_R1: assert property (@(posedge clk)
    !rst_n |-> !led);

  assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led) |-> $past(act_ev));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSE_CYCLES));

  assert_event_lights_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_ev |=> (led || suspend || clk_stop_req || low_pwr || card_bad));

  assert_card_bad_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_bad |-> !led);

  assert_cutoff_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend || clk_stop_req) |-> !led);

  assert_lowpwr_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_pwr |-> !led);

endmodule

bind sock_led_stretch sock_led_chk #(
  .PULSE_CYCLES(PULSE_CYCLES)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .card_present (card_present),
  .card_powered (card_powered),
  .card_in_reset(card_in_reset),
  .suspend      (suspend),
  .clk_stop_req (clk_stop_req),
  .pwr_state    (pwr_state),
  .act_ev       (act_ev),
  .cnt_q        (cnt_q),
  .led          (led)
);

// File: tb/test_sock_led_stretch.sv
`timescale 1ns/1ps
module test_sock_led_stretch;

  localparam int unsigned P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       card_present, card_powered, card_in_reset, card_is_bus;
  logic       rdy_irq_n, cb_frame_n, cb_irdy_n, cb_req_n;
  logic       suspend, clk_stop_req;
  logic [1:0] pwr_state;
  logic       led;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  sock_led_stretch #(.PULSE_CYCLES(P)) i_sock_led_stretch (
    .clk(clk), .rst_n(rst_n),
    .card_present(card_present), .card_powered(card_powered),
    .card_in_reset(card_in_reset), .card_is_bus(card_is_bus),
    .rdy_irq_n(rdy_irq_n), .cb_frame_n(cb_frame_n),
    .cb_irdy_n(cb_irdy_n), .cb_req_n(cb_req_n),
    .suspend(suspend), .clk_stop_req(clk_stop_req),
    .pwr_state(pwr_state), .led(led)
  );

  task automatic check(input logic exp, input string req, input string what);
    n_checks++;
    if (led !== exp) begin
      n_fail++;
      $display("FAIL %s %s: led actual=%b expected=%b at %0t", req, what, led, exp, $time);
    end
  endtask

  // Advance n rising edges, then settle 2 ns after the last.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_strobe(input int which, input logic v);
    case (which)
      0: cb_frame_n = v;
      1: cb_irdy_n  = v;
      2: cb_req_n   = v;
      default: rdy_irq_n = v;
    endcase
  endtask

  // One-cycle card-bus strobe, then follow the window to its end.
  task automatic t_single(input int which, input string req);
    set_strobe(which, 1'b0);
    step(1);
    check(1'b1, req, "first lit cycle");
    set_strobe(which, 1'b1);
    step(P - 1);
    check(1'b1, "R2", "last lit cycle");
    step(1);
    check(1'b0, "R2", "dark after window");
    step(2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(2);
    check(1'b0, "R1", "during reset");
    rst_n = 1'b1;
    step(3);
    check(1'b0, "R1", "after reset, idle");
  endtask

  task automatic t_retrigger;
    bit ok = 1'b1;
    cb_frame_n = 1'b0;
    step(1);
    cb_frame_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (led !== 1'b1) ok = 1'b0;
      step(1);
    end
    cb_irdy_n = 1'b0;
    step(1);
    cb_irdy_n = 1'b1;
    for (int i = 0; i < P; i++) begin
      if (led !== 1'b1) ok = 1'b0;
      if (i < P - 1) step(1);
    end
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R3 gap during restarted window: actual=gap expected=continuous");
    end
    step(1);
    check(1'b0, "R3", "dark P cycles after last event");
    step(2);
  endtask

  task automatic t_sixteen;
    card_is_bus = 1'b0;
    step(1);
    rdy_irq_n = 1'b0;
    step(1);
    rdy_irq_n = 1'b1;
    check(1'b0, "R5", "sync stage 1");
    step(1);
    check(1'b0, "R5", "sync stage 2");
    step(1);
    check(1'b1, "R5", "lit at third edge");
    step(P - 1);
    check(1'b1, "R5", "last lit cycle");
    step(1);
    check(1'b0, "R5", "dark after window");
    cb_frame_n = 1'b0; cb_req_n = 1'b0;
    step(3);
    check(1'b0, "R6", "card-bus strobes ignored for 16-bit card");
    cb_frame_n = 1'b1; cb_req_n = 1'b1;
    card_is_bus = 1'b1;
    step(1);
    rdy_irq_n = 1'b0;
    step(4);
    check(1'b0, "R6", "ready line ignored for card-bus card");
    rdy_irq_n = 1'b1;
    step(3);
  endtask

  task automatic t_card(input int which);
    case (which)
      0: card_present = 1'b0;
      1: card_powered = 1'b0;
      default: card_in_reset = 1'b1;
    endcase
    cb_frame_n = 1'b0;
    step(3);
    check(1'b0, "R7", "event with unusable card");
    cb_frame_n = 1'b1;
    card_present = 1'b1; card_powered = 1'b1; card_in_reset = 1'b0;
    step(1);
    check(1'b0, "R7", "no late pulse");
    cb_req_n = 1'b0;
    step(1);
    cb_req_n = 1'b1;
    step(2);
    case (which)
      0: card_present = 1'b0;
      1: card_powered = 1'b0;
      default: card_in_reset = 1'b1;
    endcase
    #1;
    check(1'b0, "R7", "dark in same cycle");
    step(1);
    card_present = 1'b1; card_powered = 1'b1; card_in_reset = 1'b0;
    #1;
    check(1'b0, "R7", "pulse not resumed");
    step(1);
    check(1'b0, "R7", "still dark");
    step(1);
  endtask

  // kind: 0 suspend, 1 clock stop, 2 D1, 3 D2
  task automatic t_cutoff(input int kind, input string req);
    cb_frame_n = 1'b0;
    step(1);
    cb_frame_n = 1'b1;
    step(2);
    check(1'b1, req, "lit before cut-off");
    case (kind)
      0: suspend = 1'b1;
      1: clk_stop_req = 1'b1;
      2: pwr_state = 2'd1;
      default: pwr_state = 2'd2;
    endcase
    #1;
    check(1'b0, req, "dark in same cycle");
    step(1);
    cb_irdy_n = 1'b0;
    step(1);
    check(1'b0, req, "event ignored while cut off");
    cb_irdy_n = 1'b1;
    suspend = 1'b0; clk_stop_req = 1'b0; pwr_state = 2'd0;
    step(1);
    check(1'b0, req, "no stale pulse after release");
    step(1);
  endtask

  task automatic t_d3;
    pwr_state = 2'd3;
    cb_req_n = 1'b0;
    step(1);
    cb_req_n = 1'b1;
    check(1'b1, "R9", "D3 does not cut off");
    step(P);
    pwr_state = 2'd0;
    step(1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    card_present = 1'b1; card_powered = 1'b1; card_in_reset = 1'b0;
    card_is_bus = 1'b1;
    rdy_irq_n = 1'b1; cb_frame_n = 1'b1; cb_irdy_n = 1'b1; cb_req_n = 1'b1;
    suspend = 1'b0; clk_stop_req = 1'b0; pwr_state = 2'd0;
    #2;
    t_reset();
    t_single(0, "R4");
    t_single(1, "R4");
    t_single(2, "R4");
    t_retrigger();
    t_sixteen();
    t_card(0);
    t_card(1);
    t_card(2);
    t_cutoff(0, "R8");
    t_cutoff(1, "R8");
    t_cutoff(2, "R9");
    t_cutoff(3, "R9");
    t_d3();
    finish_run();
  end

endmodule